// File: doc/BRIEF.md
# Rotating-Priority Shared Bus Arbiter Node

This block holds the ownership logic that one processor keeps for a bus shared by up to eight processors and one host. Every processor carries an identical copy. All copies watch the same request lines, the same host request and back-off lines, the same lock line and the same transaction-boundary strobe. Each copy also carries its own 3-bit node ID. Because every copy applies the same rules to the same inputs, all copies agree on the owner in every cycle without a central arbiter. The local copy then raises its grant only when the owner is its own node.

Processors are served in rotating order. When a tenure ends, the scan starts at the ID one above the last processor owner, modulo eight. A tenure normally lasts for as long as the owner keeps its request line high. A programmable tenure limit forces a hand-over at a transaction boundary once another processor is waiting. The shared lock line holds the bus across an indivisible read-modify-write sequence.

The host outranks all processors and takes the bus at the next boundary. A back-off from the host makes the current owner drop its transaction at once. The node that loses the bus this way reports an abort to its local master, which can then reissue the transaction later.

Top module: `mpa_node`

## Requirements
- R1: During and after reset, no processor and no host owns the bus, grant and abort are 0, and bus_owner reads 7, so that ID 0 ranks highest in the first arbitration.
- R2: When the bus is free and host_req is 0, the requesting ID that comes first in the upward scan from bus_owner+1 (modulo 8) becomes owner one clock later. req_lines bit i belongs to ID i.
- R3: If the owner's request line is 0 in a cycle, the bus passes in the next cycle to the next requester in the scan from the old owner+1, with no free cycle in between. If nobody requests, the bus becomes free.
- R4: An owner that keeps requesting stays owner while its tenure count is below fair_limit, or while no other processor requests.
- R5: The tenure count is 0 in the first owned cycle and rises by one each owned cycle, saturating at its maximum. In a cycle with xact_end=1, lock_line=0, no host request, a count of at least fair_limit and another processor requesting, ownership moves to the next requester in the scan.
- R6: While lock_line=1 and the owner keeps requesting, neither the tenure limit nor host_req can move the bus away from it.
- R7: host_req outranks all processor requests. The host gains the bus when the bus is free, when the owner drops its request, or at a cycle with xact_end=1 and lock_line=0. host_owns rises one clock later.
- R8: backoff=1 while a processor owns the bus gives the bus to the host in the next cycle, whatever the lock or the boundary. If that processor is this node, abort is 1 for exactly that one cycle.
- R9: The host keeps the bus while host_req or backoff is 1. When both are 0, processors are arbitrated from the last processor owner+1.
- R10: grant is 1 exactly when proc_owns is 1 and bus_owner equals my_id.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| my_id | input | 3 | This node's ID |
| req_lines | input | 8 | Shared processor request lines, bit i for ID i |
| host_req | input | 1 | Host wants the bus |
| backoff | input | 1 | Host orders the current owner off the bus |
| lock_line | input | 1 | Shared lock, held by the owner during an indivisible sequence |
| xact_end | input | 1 | Current bus transaction completes this cycle |
| fair_limit | input | 8 | Tenure cycles before a forced hand-over becomes allowed |
| grant | output | 1 | This node owns the bus |
| proc_owns | output | 1 | Some processor owns the bus |
| host_owns | output | 1 | The host owns the bus |
| bus_owner | output | 3 | Current, or most recent, processor owner |
| abort | output | 1 | One-cycle pulse: this node's transaction was abandoned for back-off |

## Verification
The bench targets several corner cases.
- Scan wrap-around past ID 7. A design that scans from zero would hand the bus to the wrong node.
- A forced hand-over at exactly the tenure limit. An off-by-one counter would move the bus one cycle early or one cycle late.
- A lock that stays set while a host request and an expired tenure are both pending. A design that ignores the lock would split a read-modify-write sequence.
- A back-off arriving while locked and mid-transaction. A design that waits for the boundary, or that pulses abort on the wrong node, would show up there.
- A host release that falls straight into rotation. A design that restarts the scan at ID 0 would show up there.

Long random runs with sticky request patterns and changing limits are compared cycle by cycle against a reference model written in the bench.

// File: rtl/mpa_pkg.sv
package mpa_pkg;
    typedef enum logic [1:0] {
        ST_FREE = 2'd0,
        ST_PROC = 2'd1,
        ST_HOST = 2'd2
    } own_state_e;
endpackage

// File: rtl/mpa_rr_pick.sv
module mpa_rr_pick #(
    parameter int ID_W = 3
) (
    input  logic [(1<<ID_W)-1:0] req,
    input  logic [ID_W-1:0]      base,
    output logic                 valid,
    output logic [ID_W-1:0]      winner
);
    localparam int N = 1 << ID_W;

    logic [N-1:0] rot;

    // rot[i] is the request of ID base+1+i (mod N)
    for (genvar i = 0; i < N; i++) begin : g_rot
        localparam logic [ID_W-1:0] OFF = ID_W'(i + 1);
        logic [ID_W-1:0] idx;
        assign idx    = base + OFF;
        assign rot[i] = req[idx];
    end

    always_comb begin
        valid  = 1'b0;
        winner = base;
        for (int i = N - 1; i >= 0; i--) begin
            if (rot[i]) begin
                valid  = 1'b1;
                winner = base + ID_W'(i + 1);
            end
        end
    end

    // R2: the chosen ID is always a requester
    always_comb begin
        a_r2_pick_requested: assert (!valid || req[winner]);
    end
endmodule

// File: rtl/mpa_tenure.sv
module mpa_tenure #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             reached
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (run && cnt_q != CNT_MAX) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign reached = (cnt_q >= limit);

    a_r5_count_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && run && !clear) |=> cnt_q == CNT_MAX);

    a_r5_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> cnt_q == '0);
endmodule

// File: rtl/mpa_node.sv
module mpa_node
    import mpa_pkg::*;
#(
    parameter int ID_W  = 3,
    parameter int CNT_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ID_W-1:0]      my_id,
    input  logic [(1<<ID_W)-1:0] req_lines,
    input  logic                 host_req,
    input  logic                 backoff,
    input  logic                 lock_line,
    input  logic                 xact_end,
    input  logic [CNT_W-1:0]     fair_limit,
    output logic                 grant,
    output logic                 proc_owns,
    output logic                 host_owns,
    output logic [ID_W-1:0]      bus_owner,
    output logic                 abort
);
    localparam int N = 1 << ID_W;

    typedef struct packed {
        own_state_e      st;
        logic [ID_W-1:0] owner;
        logic            abort;
    } node_regs_t;

    node_regs_t r_d, r_q;
    logic            new_grant;
    logic            pick_valid;
    logic [ID_W-1:0] pick_id;
    logic            tenure_hit;
    logic            own_req;
    logic            others_req;
    logic [N-1:0]    owner_mask;

    mpa_rr_pick #(.ID_W(ID_W)) u_pick (
        .req    (req_lines),
        .base   (r_q.owner),
        .valid  (pick_valid),
        .winner (pick_id)
    );

    mpa_tenure #(.CNT_W(CNT_W)) u_tenure (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (new_grant),
        .run     (r_q.st == ST_PROC),
        .limit   (fair_limit),
        .reached (tenure_hit)
    );

    assign owner_mask = N'(1) << r_q.owner;
    assign own_req    = req_lines[r_q.owner];
    assign others_req = |(req_lines & ~owner_mask);

    always_comb begin
        r_d       = r_q;
        r_d.abort = 1'b0;
        new_grant = 1'b0;
        unique case (r_q.st)
            ST_FREE: begin
                if (host_req) begin
                    r_d.st = ST_HOST;
                end else if (pick_valid) begin
                    r_d.st    = ST_PROC;
                    r_d.owner = pick_id;
                    new_grant = 1'b1;
                end
            end
            ST_PROC: begin
                if (backoff) begin
                    r_d.st    = ST_HOST;
                    r_d.abort = (r_q.owner == my_id);
                end else if (!own_req) begin
                    if (host_req) begin
                        r_d.st = ST_HOST;
                    end else if (pick_valid) begin
                        r_d.owner = pick_id;
                        new_grant = 1'b1;
                    end else begin
                        r_d.st = ST_FREE;
                    end
                end else if (xact_end && !lock_line) begin
                    if (host_req) begin
                        r_d.st = ST_HOST;
                    end else if (tenure_hit && others_req) begin
                        r_d.owner = pick_id;
                        new_grant = 1'b1;
                    end
                end
            end
            ST_HOST: begin
                if (!host_req && !backoff) begin
                    if (pick_valid) begin
                        r_d.st    = ST_PROC;
                        r_d.owner = pick_id;
                        new_grant = 1'b1;
                    end else begin
                        r_d.st = ST_FREE;
                    end
                end
            end
            default: r_d.st = ST_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st    <= ST_FREE;
            r_q.owner <= {ID_W{1'b1}};
            r_q.abort <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign proc_owns = (r_q.st == ST_PROC);
    assign host_owns = (r_q.st == ST_HOST);
    assign bus_owner = r_q.owner;
    assign grant     = proc_owns && (r_q.owner == my_id);
    assign abort     = r_q.abort;

    a_r8_backoff_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_PROC && backoff) |=> r_q.st == ST_HOST);

    a_r8_abort_after_proc: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.abort |-> (r_q.st == ST_HOST && $past(r_q.st) == ST_PROC));

    a_r6_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_PROC && lock_line && own_req && !backoff)
        |=> (r_q.st == ST_PROC && $stable(r_q.owner)));

    a_r5_fair_handover: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_PROC && own_req && xact_end && !lock_line && !backoff
         && !host_req && tenure_hit && others_req)
        |=> (r_q.st == ST_PROC && r_q.owner != $past(r_q.owner)));

    a_r9_host_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_HOST && (host_req || backoff)) |=> r_q.st == ST_HOST);

    a_r10_grant_single: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> !host_owns);
endmodule

// File: tb/mpa_node_test.sv
module mpa_node_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] my_id = 3'd2;
    logic [7:0] req_lines = 8'h00;
    logic       host_req = 1'b0;
    logic       backoff = 1'b0;
    logic       lock_line = 1'b0;
    logic       xact_end = 1'b0;
    logic [7:0] fair_limit = 8'd200;
    logic       grant, proc_owns, host_owns, abort;
    logic [2:0] bus_owner;

    int nchk = 0;
    int nerr = 0;

    // reference model state: 0 free, 1 processor, 2 host
    int       m_st = 0;
    int       m_own = 7;
    int       m_cnt = 0;
    bit       m_abort = 1'b0;
    string    m_tag = "R1";

    always #5 clk = ~clk;

    mpa_node uut (
        .clk(clk), .rst_n(rst_n), .my_id(my_id), .req_lines(req_lines),
        .host_req(host_req), .backoff(backoff), .lock_line(lock_line),
        .xact_end(xact_end), .fair_limit(fair_limit), .grant(grant),
        .proc_owns(proc_owns), .host_owns(host_owns), .bus_owner(bus_owner),
        .abort(abort)
    );

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // first requester scanning upward from base+1, modulo 8; -1 if none
    function automatic int pick(input logic [7:0] r, input int base);
        for (int i = 1; i <= 8; i++) begin
            if (r[(base + i) % 8]) return (base + i) % 8;
        end
        return -1;
    endfunction

    task automatic model_step();
        int  nst = m_st;
        int  nown = m_own;
        bit  clr = 1'b0;
        int  p = pick(req_lines, m_own);
        bit  others = |(req_lines & ~(8'h01 << m_own));
        m_abort = 1'b0;
        case (m_st)
            0: begin
                if (host_req) begin nst = 2; m_tag = "R7"; end
                else if (p >= 0) begin nst = 1; nown = p; clr = 1; m_tag = "R2"; end
                else m_tag = "R2";
            end
            1: begin
                if (backoff) begin
                    nst = 2; m_abort = (m_own == int'(my_id)); m_tag = "R8";
                end else if (!req_lines[m_own]) begin
                    if (host_req) begin nst = 2; m_tag = "R7"; end
                    else if (p >= 0) begin nown = p; clr = 1; m_tag = "R3"; end
                    else begin nst = 0; m_tag = "R3"; end
                end else if (xact_end && !lock_line) begin
                    if (host_req) begin nst = 2; m_tag = "R7"; end
                    else if (m_cnt >= int'(fair_limit) && others) begin
                        nown = p; clr = 1; m_tag = "R5";
                    end else m_tag = "R4";
                end else if (lock_line) m_tag = "R6";
                else m_tag = "R4";
            end
            default: begin
                m_tag = "R9";
                if (!host_req && !backoff) begin
                    if (p >= 0) begin nst = 1; nown = p; clr = 1; end
                    else nst = 0;
                end
            end
        endcase
        if (clr) m_cnt = 0;
        else if (m_st == 1 && m_cnt < 255) m_cnt = m_cnt + 1;
        m_st = nst;
        m_own = nown;
    endtask

    task automatic model_compare();
        chk({m_tag, " proc_owns"}, int'(proc_owns), int'(m_st == 1));
        chk({m_tag, " host_owns"}, int'(host_owns), int'(m_st == 2));
        chk({m_tag, " bus_owner"}, int'(bus_owner), m_own);
        chk({m_tag, " abort"}, int'(abort), int'(m_abort));
        chk("R10 grant", int'(grant), int'(m_st == 1 && m_own == int'(my_id)));
    endtask

    // one clock: inputs already driven; model follows the edge; sample at negedge
    task automatic step();
        @(posedge clk);
        model_step();
        @(negedge clk);
        model_compare();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk("R1 grant", int'(grant), 0);
        chk("R1 proc_owns", int'(proc_owns), 0);
        chk("R1 host_owns", int'(host_owns), 0);
        chk("R1 abort", int'(abort), 0);
        chk("R1 bus_owner", int'(bus_owner), 7);
        rst_n = 1'b1;

        // R2: last owner 7, requesters 2 and 5 -> 2 (scan wraps through 0)
        req_lines = 8'b0010_0100;
        step();
        chk("R2 owner", int'(bus_owner), 2);
        chk("R10 own grant", int'(grant), 1);

        // R4: owner keeps while limit far away
        xact_end = 1'b1;
        repeat (4) step();
        chk("R4 kept", int'(bus_owner), 2);

        // R3: owner drops -> 5 with no free cycle
        req_lines = 8'b0010_0000;
        fair_limit = 8'd3;
        step();
        chk("R3 rotate", int'(bus_owner), 5);
        chk("R3 proc_owns", int'(proc_owns), 1);

        // R5: limit 3, requesters 5 and 1; hand-over on the fourth boundary
        req_lines = 8'b0010_0010;
        repeat (3) step();
        chk("R5 before limit", int'(bus_owner), 5);
        step();
        chk("R5 at limit", int'(bus_owner), 1);

        // R6: lock holds against limit 0 and a host request
        fair_limit = 8'd0;
        req_lines = 8'b0000_0110;
        lock_line = 1'b1;
        host_req = 1'b1;
        repeat (3) step();
        chk("R6 locked owner", int'(bus_owner), 1);
        chk("R6 host kept out", int'(host_owns), 0);

        // R7: lock released at a boundary -> host
        lock_line = 1'b0;
        step();
        chk("R7 host owns", int'(host_owns), 1);
        chk("R7 abort quiet", int'(abort), 0);

        // R9: host releases -> scan from 1: requesters 1,2 -> 2
        host_req = 1'b0;
        step();
        chk("R9 after host", int'(bus_owner), 2);

        // R8: back-off while locked mid-transaction, this node owns
        lock_line = 1'b1;
        xact_end = 1'b0;
        backoff = 1'b1;
        step();
        chk("R8 host owns", int'(host_owns), 1);
        chk("R8 abort", int'(abort), 1);
        backoff = 1'b0;
        lock_line = 1'b0;
        step();
        chk("R8 abort one cycle", int'(abort), 0);
        chk("R9 rotate after backoff", int'(bus_owner), 1);

        // random phase
        for (int blk = 0; blk < 8; blk++) begin
            my_id = 3'($urandom_range(0, 7));
            fair_limit = 8'($urandom_range(0, 11));
            for (int c = 0; c < 500; c++) begin
                for (int b = 0; b < 8; b++) begin
                    if ($urandom_range(0, 7) == 0) req_lines[b] = ~req_lines[b];
                end
                if ($urandom_range(0, 39) == 0) host_req = ~host_req;
                backoff = ($urandom_range(0, 59) == 0);
                if ($urandom_range(0, 9) == 0) lock_line = ~lock_line;
                xact_end = 1'($urandom_range(0, 1));
                step();
            end
        end

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule